// File: doc/BRIEF.md
# Clock Compensation Skip FIFO

This block is an elastic buffer that sits between a recovered receive clock and a local reference clock. It carries 10-bit code groups that have already been line decoded. The two clocks run at nearly the same rate. Each clock owns one pointer into a 20-word store. Each pointer moves to the other side as a one-bit-per-step cyclic code through a two-flop synchronizer, and each side computes the fill level from its own pointer and the synchronized remote one.

Two 20-bit match patterns are programmed. Each one is a control code group followed by a skip code group. One pattern is meant for positive running disparity and the other for negative. The buffer adjusts its fill only directly after a matched control-then-skip pair. When the store is filling up, the write side drops the skip word. When the store is running low, the read side emits the skip word a second time. A skip word with neutral disparity does not disturb running disparity, and a configuration error flags a skip field that is not neutral.

Top module: `skip_elastic_fifo`

## Requirements
- R1: While reset is active and directly after reset, `rd_valid`, `ins_evt`, `del_evt`, `underflow` and `full` are all low.
- R2: Words leave the read port in the order they were written. The store holds 20 words. `full` is high exactly while 20 words are stored. A word presented while `full` is high is discarded.
- R3: After reset, no word is read until at least 10 words have been written.
- R4: In each pattern, bits [19:10] hold the control group and bits [9:0] hold the skip group. Take two consecutive valid write words that equal the control and skip groups of one pattern. If the write-side fill is 14 or more when the skip word arrives, that skip word is not stored, and `del_evt` pulses high for one write-clock cycle. Below 14 it is stored.
- R5: A matched control-then-skip pair can be read out. If the read-side fill is 6 or less when its skip word is read, the next read outputs the same skip word again without consuming a stored word, and `ins_evt` is high in that cycle. Above 6 there is no insertion. Each pair causes at most one insertion.
- R6: Both programmed patterns trigger deletion and insertion in the same way.
- R7: A read enabled on an empty store (after start) outputs the skip group of `pat_pos` with `rd_valid` high, pulses `underflow` for that cycle, and consumes nothing.
- R8: `cfg_err` is high whenever the skip group of either pattern does not contain exactly five ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive clock |
| wr_rst_n | input | 1 | Active-low reset, write domain |
| wr_word | input | 10 | Incoming code group |
| wr_valid | input | 1 | Incoming code group is valid |
| rd_clk | input | 1 | Local reference clock |
| rd_rst_n | input | 1 | Active-low reset, read domain |
| rd_en | input | 1 | Read request for this cycle |
| rd_word | output | 10 | Outgoing code group |
| rd_valid | output | 1 | `rd_word` carries a word this cycle |
| pat_pos | input | 20 | Control+skip pattern for positive disparity |
| pat_neg | input | 20 | Control+skip pattern for negative disparity |
| full | output | 1 | Store holds 20 words (write-side view) |
| del_evt | output | 1 | A skip word was dropped (write domain pulse) |
| ins_evt | output | 1 | A skip word was repeated (read domain pulse) |
| underflow | output | 1 | Read of an empty store (read domain pulse) |
| cfg_err | output | 1 | A skip group is not disparity neutral |

## Verification
A corrupted pointer or a wrong fill value first shows as a word missing, doubled or out of order in the read stream, within a few read cycles of the next read. A fill that is off by a few words moves the point where `full` rises or where a matched skip word is dropped or repeated. The bench therefore writes exact word counts before each readout, holds reads off while it writes, and compares the whole read sequence and the event counts against the counts it expects from the watermarks.

// File: rtl/ske_pkg.sv
`timescale 1ns/1ps
package ske_pkg;
  localparam int WORD_W = 10;
  localparam int PAT_W  = 2 * WORD_W;
  typedef logic [WORD_W-1:0] word_t;

  // number of set bits in a code group
  function automatic int unsigned ones_of(input word_t w);
    int unsigned n;
    n = 0;
    for (int i = 0; i < WORD_W; i++) n += int'(w[i]);
    return n;
  endfunction
endpackage

// File: rtl/ske_ptr.sv
`timescale 1ns/1ps
// One pointer side: counter modulo 2*DEPTH with a cyclic one-bit-step code,
// synchronizer for the remote code, and the fill level seen from this side.
module ske_ptr #(
  parameter int DEPTH    = 20,
  parameter bit LOCAL_WR = 1'b1,
  parameter int PW       = $clog2(2 * DEPTH),
  parameter int AW       = $clog2(DEPTH),
  parameter int LW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic [PW-1:0] far_gray,
  output logic [PW-1:0] gray_o,
  output logic [AW-1:0] addr_o,
  output logic [LW-1:0] fill_o
);
  localparam int MOD  = 2 * DEPTH;
  localparam int GOFF = ((1 << PW) - MOD) / 2;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] idx_q, idx_n, gray_q, gray_n;
  logic [PW-1:0] sync1_q, sync2_q, far_idx;
  logic [PW:0]   w_e, r_e, diff;

  always_comb begin
    idx_n = idx_q;
    if (inc) idx_n = (idx_q == PW'(MOD - 1)) ? '0 : idx_q + 1'b1;
    gray_n = to_gray(idx_n + PW'(GOFF));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      gray_q  <= to_gray(PW'(GOFF));
      sync1_q <= to_gray(PW'(GOFF));
      sync2_q <= to_gray(PW'(GOFF));
    end else begin
      idx_q   <= idx_n;
      gray_q  <= gray_n;
      sync1_q <= far_gray;
      sync2_q <= sync1_q;
    end
  end

  assign far_idx = from_gray(sync2_q) - PW'(GOFF);

  generate
    if (LOCAL_WR) begin : g_wr_side
      assign w_e = {1'b0, idx_q};
      assign r_e = {1'b0, far_idx};
    end else begin : g_rd_side
      assign w_e = {1'b0, far_idx};
      assign r_e = {1'b0, idx_q};
    end
  endgenerate

  assign diff   = (w_e >= r_e) ? (w_e - r_e) : (w_e + (PW+1)'(MOD) - r_e);
  assign fill_o = LW'(diff);
  assign gray_o = gray_q;
  assign addr_o = (idx_q >= PW'(DEPTH)) ? AW'(idx_q - PW'(DEPTH)) : AW'(idx_q);

  // R2: the code crossing domains never changes more than one bit per cycle
  p_gray_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray_q ^ $past(gray_q)) <= 1);
  // R2: the level seen from either side never exceeds the store size
  p_fill_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_o <= LW'(DEPTH));
endmodule

// File: rtl/ske_wr_ctrl.sv
`timescale 1ns/1ps
module ske_wr_ctrl
  import ske_pkg::*;
#(
  parameter int DEPTH   = 20,
  parameter int HI_MARK = 14,
  parameter int PW      = $clog2(2 * DEPTH),
  parameter int AW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  word_t         in_word,
  input  logic          in_valid,
  input  word_t         ctl_a,
  input  word_t         skip_a,
  input  word_t         ctl_b,
  input  word_t         skip_b,
  input  logic [PW-1:0] rd_gray,
  output logic [PW-1:0] wr_gray,
  output logic [AW-1:0] wr_addr,
  output logic          we,
  output logic          full,
  output logic          del_evt
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [LW-1:0] HI_L   = LW'(HI_MARK);
  localparam logic [LW-1:0] FULL_L = LW'(DEPTH);

  word_t       prev_q, prev_n;
  logic        pvld_q, pvld_n;
  logic        del_q, del_n;
  logic        pair_hit, drop;
  logic [LW-1:0] fill;

  ske_ptr #(.DEPTH(DEPTH), .LOCAL_WR(1'b1), .PW(PW), .AW(AW), .LW(LW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .inc(we), .far_gray(rd_gray),
    .gray_o(wr_gray), .addr_o(wr_addr), .fill_o(fill)
  );

  always_comb begin
    pair_hit = in_valid && pvld_q &&
               (((prev_q == ctl_a) && (in_word == skip_a)) ||
                ((prev_q == ctl_b) && (in_word == skip_b)));
    drop   = pair_hit && (fill >= HI_L);
    full   = (fill == FULL_L);
    we     = in_valid && !drop && !full;
    prev_n = in_valid ? in_word : prev_q;
    pvld_n = pvld_q | in_valid;
    del_n  = drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pvld_q <= 1'b0;
      del_q  <= 1'b0;
    end else begin
      prev_q <= prev_n;
      pvld_q <= pvld_n;
      del_q  <= del_n;
    end
  end

  assign del_evt = del_q;

  // R4: a dropped skip word does not advance the write pointer
  p_del_no_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    del_evt |-> $stable(wr_gray));
  // R2: nothing is stored while the store is full
  p_full_no_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(full) |-> $stable(wr_gray));
endmodule

// File: rtl/ske_rd_ctrl.sv
`timescale 1ns/1ps
module ske_rd_ctrl
  import ske_pkg::*;
#(
  parameter int DEPTH     = 20,
  parameter int LO_MARK   = 6,
  parameter int START_LVL = 10,
  parameter int PW        = $clog2(2 * DEPTH),
  parameter int AW        = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  word_t         mem_word,
  input  word_t         ctl_a,
  input  word_t         skip_a,
  input  word_t         ctl_b,
  input  word_t         skip_b,
  input  logic [PW-1:0] wr_gray,
  output logic [PW-1:0] rd_gray,
  output logic [AW-1:0] rd_addr,
  output word_t         out_word,
  output logic          out_valid,
  output logic          ins_evt,
  output logic          underflow
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [LW-1:0] LO_L    = LW'(LO_MARK);
  localparam logic [LW-1:0] START_L = LW'(START_LVL);

  logic [LW-1:0] fill;
  logic  started_q, started_n, pend_q, pend_n;
  logic  vld_q, vld_n, ins_q, ins_n, unf_q, unf_n, inc;
  word_t out_q, out_n;
  logic  pair_hit;

  ske_ptr #(.DEPTH(DEPTH), .LOCAL_WR(1'b0), .PW(PW), .AW(AW), .LW(LW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .inc(inc), .far_gray(wr_gray),
    .gray_o(rd_gray), .addr_o(rd_addr), .fill_o(fill)
  );

  always_comb begin
    pair_hit  = ((out_q == ctl_a) && (mem_word == skip_a)) ||
                ((out_q == ctl_b) && (mem_word == skip_b));
    started_n = started_q | (fill >= START_L);
    pend_n    = pend_q;
    out_n     = out_q;
    vld_n     = 1'b0;
    ins_n     = 1'b0;
    unf_n     = 1'b0;
    inc       = 1'b0;
    if (rd_en) begin
      if (pend_q) begin
        vld_n  = 1'b1;
        ins_n  = 1'b1;
        pend_n = 1'b0;
      end else if (started_q) begin
        vld_n = 1'b1;
        if (fill == '0) begin
          out_n = skip_a;
          unf_n = 1'b1;
        end else begin
          out_n = mem_word;
          inc   = 1'b1;
          if (pair_hit && (fill <= LO_L)) pend_n = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      pend_q    <= 1'b0;
      out_q     <= '0;
      vld_q     <= 1'b0;
      ins_q     <= 1'b0;
      unf_q     <= 1'b0;
    end else begin
      started_q <= started_n;
      pend_q    <= pend_n;
      out_q     <= out_n;
      vld_q     <= vld_n;
      ins_q     <= ins_n;
      unf_q     <= unf_n;
    end
  end

  assign out_word  = out_q;
  assign out_valid = vld_q;
  assign ins_evt   = ins_q;
  assign underflow = unf_q;

  // R5: an insertion repeats the previous word and consumes nothing
  p_ins_repeat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_evt |-> (out_valid && (out_word == $past(out_word)) && $stable(rd_gray)));
  // R5: never two insertions in a row
  p_ins_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_evt |=> !ins_evt);
  // R7: an underflow read leaves the read pointer where it was
  p_unf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (out_valid && $stable(rd_gray)));
  // R1: outputs quiet in the first cycle after reset release
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
endmodule

// File: rtl/skip_elastic_fifo.sv
`timescale 1ns/1ps
module skip_elastic_fifo
  import ske_pkg::*;
#(
  parameter int DEPTH     = 20,
  parameter int HI_MARK   = 14,
  parameter int LO_MARK   = 6,
  parameter int START_LVL = 10
) (
  input  logic             wr_clk,
  input  logic             wr_rst_n,
  input  logic [9:0]       wr_word,
  input  logic             wr_valid,
  input  logic             rd_clk,
  input  logic             rd_rst_n,
  input  logic             rd_en,
  output logic [9:0]       rd_word,
  output logic             rd_valid,
  input  logic [19:0]      pat_pos,
  input  logic [19:0]      pat_neg,
  output logic             full,
  output logic             del_evt,
  output logic             ins_evt,
  output logic             underflow,
  output logic             cfg_err
);
  localparam int PW = $clog2(2 * DEPTH);
  localparam int AW = $clog2(DEPTH);

  word_t ctl_a, skip_a, ctl_b, skip_b;
  assign ctl_a  = pat_pos[PAT_W-1:WORD_W];
  assign skip_a = pat_pos[WORD_W-1:0];
  assign ctl_b  = pat_neg[PAT_W-1:WORD_W];
  assign skip_b = pat_neg[WORD_W-1:0];

  assign cfg_err = (ones_of(skip_a) != WORD_W / 2) || (ones_of(skip_b) != WORD_W / 2);

  // reset release synchronized to each clock
  logic [1:0] wr_rs_q, rd_rs_q;
  logic       wr_rst_s, rd_rst_s;
  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) wr_rs_q <= 2'b00;
    else           wr_rs_q <= {wr_rs_q[0], 1'b1};
  end
  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) rd_rs_q <= 2'b00;
    else           rd_rs_q <= {rd_rs_q[0], 1'b1};
  end
  assign wr_rst_s = wr_rs_q[1];
  assign rd_rst_s = rd_rs_q[1];

  logic [PW-1:0] wr_gray, rd_gray;
  logic [AW-1:0] wr_addr, rd_addr;
  logic          we;
  word_t         store [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) store[wr_addr] <= wr_word;
  end

  ske_wr_ctrl #(.DEPTH(DEPTH), .HI_MARK(HI_MARK), .PW(PW), .AW(AW)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_s), .in_word(wr_word), .in_valid(wr_valid),
    .ctl_a(ctl_a), .skip_a(skip_a), .ctl_b(ctl_b), .skip_b(skip_b),
    .rd_gray(rd_gray), .wr_gray(wr_gray), .wr_addr(wr_addr), .we(we),
    .full(full), .del_evt(del_evt)
  );

  ske_rd_ctrl #(.DEPTH(DEPTH), .LO_MARK(LO_MARK), .START_LVL(START_LVL),
                .PW(PW), .AW(AW)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_s), .rd_en(rd_en), .mem_word(store[rd_addr]),
    .ctl_a(ctl_a), .skip_a(skip_a), .ctl_b(ctl_b), .skip_b(skip_b),
    .wr_gray(wr_gray), .rd_gray(rd_gray), .rd_addr(rd_addr),
    .out_word(rd_word), .out_valid(rd_valid), .ins_evt(ins_evt),
    .underflow(underflow)
  );

  // R8: the error flag tracks neutrality of both skip groups
  always_comb begin
    if (wr_rst_s) begin
      p_cfg_flag_r8: assert (cfg_err == (($countones(skip_a) != 5) || ($countones(skip_b) != 5)));
    end
  end
endmodule

// File: tb/test_skip_elastic_fifo.sv
`timescale 1ns/1ps
module test_skip_elastic_fifo;
  logic       wr_clk = 0, rd_clk = 0;
  logic       wr_rst_n = 0, rd_rst_n = 0;
  logic [9:0] wr_word = '0;
  logic       wr_valid = 0, rd_en = 0;
  logic [19:0] pat_pos = '0, pat_neg = '0;
  logic [9:0] rd_word;
  logic       rd_valid, full, del_evt, ins_evt, underflow, cfg_err;

  localparam logic [9:0] CA = 10'h0FA, SA = 10'h2A9, CB = 10'h305, SB = 10'h156;

  // {ctl pos, skip pos, ctl neg, skip neg, expected cfg_err}
  localparam logic [40:0] CFG_VEC [6] = '{
    {CA, SA,     CB, SB,     1'b0},
    {CA, 10'h3FF, CB, SB,    1'b1},
    {CA, SA,     CB, 10'h000, 1'b1},
    {CA, 10'h01F, CB, 10'h3E0, 1'b0},
    {CA, 10'h00F, CB, SB,    1'b1},
    {CA, SA,     CB, 10'h03F, 1'b1}
  };

  always #2.5 rd_clk = ~rd_clk;
  always #2.65 wr_clk = ~wr_clk;

  skip_elastic_fifo i_skip_elastic_fifo (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_word(wr_word), .wr_valid(wr_valid),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_word(rd_word),
    .rd_valid(rd_valid), .pat_pos(pat_pos), .pat_neg(pat_neg), .full(full),
    .del_evt(del_evt), .ins_evt(ins_evt), .underflow(underflow), .cfg_err(cfg_err)
  );

  int n_chk = 0, n_err = 0;
  int log_n = 0, ins_cnt = 0, unf_cnt = 0, del_cnt = 0;
  logic [9:0] log_mem [1024];

  always @(negedge rd_clk) begin
    if (rd_valid && log_n < 1024) begin
      log_mem[log_n] = rd_word;
      log_n++;
    end
    if (ins_evt) ins_cnt++;
    if (underflow) unf_cnt++;
  end
  always @(negedge wr_clk) if (del_evt) del_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_log(input int pos, input logic [9:0] exp, input string req);
    chk(log_mem[pos] === exp, req, int'(log_mem[pos]), int'(exp));
  endtask

  task automatic put(input logic [9:0] w);
    @(negedge wr_clk);
    wr_word  = w;
    wr_valid = 1'b1;
  endtask

  task automatic put_idle();
    @(negedge wr_clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd_wait(input int n);
    repeat (n) @(negedge rd_clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int mark, ins0;
    // R8: configuration vectors walked by one loop
    for (int i = 0; i < 6; i++) begin
      pat_pos = CFG_VEC[i][40:21];
      pat_neg = CFG_VEC[i][20:1];
      #1;
      chk(cfg_err === CFG_VEC[i][0], "R8", int'(cfg_err), int'(CFG_VEC[i][0]));
    end
    pat_pos = {CA, SA};
    pat_neg = {CB, SB};

    // R1: reset state
    rd_wait(4);
    chk({rd_valid, ins_evt, underflow, full, del_evt} === 5'b0, "R1 in reset",
        int'({rd_valid, ins_evt, underflow, full, del_evt}), 0);
    wr_rst_n = 1;
    rd_rst_n = 1;
    rd_wait(6);
    chk({rd_valid, ins_evt, underflow, full, del_evt} === 5'b0, "R1 after reset",
        int'({rd_valid, ins_evt, underflow, full, del_evt}), 0);

    // R3: nothing read before ten words
    rd_en = 1;
    for (int i = 0; i < 9; i++) put(10'h010 + 10'(i));
    put_idle();
    rd_wait(30);
    chk(log_n == 0, "R3 blocked at nine words", log_n, 0);
    put(10'h019);
    put_idle();
    rd_wait(30);
    @(negedge rd_clk);
    rd_en = 0;
    for (int i = 0; i < 10; i++) chk_log(i, 10'h010 + 10'(i), "R2 R3 start order");
    chk_log(10, SA, "R7 underflow word");
    chk(unf_cnt > 0, "R7 underflow pulse", unf_cnt, 1);
    rd_wait(10);

    // R4: delete at high fill, R2: full and discard
    mark = log_n;
    for (int i = 0; i < 13; i++) put(10'h040 + 10'(i));
    put(CA);
    put(SA);
    for (int i = 0; i < 6; i++) put(10'h060 + 10'(i));
    put(10'h07F);
    put_idle();
    put_idle();
    chk(del_cnt == 1, "R4 delete count", del_cnt, 1);
    chk(full === 1'b1, "R2 full at 20", int'(full), 1);
    rd_wait(10);
    rd_en = 1;
    rd_wait(40);
    rd_en = 0;
    for (int i = 0; i < 13; i++) chk_log(mark + i, 10'h040 + 10'(i), "R2 order");
    chk_log(mark + 13, CA, "R4 control kept");
    for (int i = 0; i < 6; i++) chk_log(mark + 14 + i, 10'h060 + 10'(i), "R4 skip removed");
    chk_log(mark + 20, SA, "R2 extra word discarded");
    rd_wait(4);
    chk(full === 1'b0, "R2 full clears", int'(full), 0);
    chk(ins_cnt == 0, "R5 no insert without pair", ins_cnt, 0);

    // R5 R6: insert at low fill using the negative pattern
    mark = log_n;
    ins0 = ins_cnt;
    put(CB);
    put(SB);
    for (int i = 0; i < 3; i++) put(10'h0A0 + 10'(i));
    put_idle();
    rd_wait(20);
    rd_en = 1;
    rd_wait(30);
    rd_en = 0;
    chk_log(mark, CB, "R6 control");
    chk_log(mark + 1, SB, "R4 skip kept at low fill");
    chk_log(mark + 2, SB, "R5 R6 skip repeated");
    for (int i = 0; i < 3; i++) chk_log(mark + 3 + i, 10'h0A0 + 10'(i), "R5 data after insert");
    chk(ins_cnt == ins0 + 1, "R5 one insert", ins_cnt, ins0 + 1);
    rd_wait(10);

    // R5: no insertion above the low watermark
    mark = log_n;
    ins0 = ins_cnt;
    put(CB);
    put(SB);
    for (int i = 0; i < 10; i++) put(10'h0C0 + 10'(i));
    put_idle();
    rd_wait(20);
    rd_en = 1;
    rd_wait(30);
    rd_en = 0;
    chk_log(mark, CB, "R5 control");
    chk_log(mark + 1, SB, "R5 skip once");
    for (int i = 0; i < 10; i++) chk_log(mark + 2 + i, 10'h0C0 + 10'(i), "R5 no repeat at high fill");
    chk(ins_cnt == ins0, "R5 insert count unchanged", ins_cnt, ins0);
    chk(del_cnt == 1, "R4 no delete at low fill", del_cnt, 1);

    finish_run();
  end
endmodule